// File: doc/BRIEF.md
# I2C Receive Byte Count and Acknowledge Controller

This block sits beside the byte shifter of an I2C controller whose received bytes land in a FIFO. Software programs how many bytes it wants. The block then counts down once for every byte that the shifter hands over. It drives the acknowledge level the shifter sends back for the byte now arriving, and it raises an interrupt flag once the last wanted byte is in. The last byte can be answered with acknowledge or not-acknowledge. A separate policy bit, set by software, makes that choice. Every other byte is acknowledged whenever general acknowledge is enabled.

The same interrupt flag also reports a transmit-side event. When a byte transfer, including its acknowledge bit, finishes while the transmit FIFO holds no data, a transmit-empty flag is latched and the interrupt is raised. Software can change the count and the policy bit only while the FIFO is enabled and the interrupt flag is set. It clears the flag by writing 0 to it.

Received bytes arrive over a valid/ready handshake. The shifter holds `rx_valid` high for a finished byte. A byte is taken on a clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` is low for as long as the interrupt flag is set, so the shifter must hold off while software services the interrupt. Counting and the acknowledge decision are frozen during that time.

Top module: `i2c_rx_count_ctrl`

## Requirements
- R1: After reset, the count reads 0, the policy bit reads 0, and both `irq_flag` and `txe_flag` are 0.
- R2: A configuration write of count value 0 programs a 16-byte reception. The read-back value is 0, then 15 after the first byte, and the interrupt is raised only by the sixteenth taken byte.
- R3: Each taken byte lowers the stored count by one. `rd_cnt` shows the low 4 bits of the bytes still to be received, starting on the edge that takes the byte.
- R4: A byte is taken only on an edge where `rx_valid` and `rx_ready` are both high. `rx_ready` equals NOT `irq_flag`. Bytes offered while the flag is set leave the count unchanged.
- R5: Taking a byte while the count is 1 brings the count to 0 and sets `irq_flag` on that same edge.
- R6: While `ack_en` is 1 and the count is not 1 (including 0), `ack_out` is 1, meaning acknowledge. While `ack_en` is 0, `ack_out` is 0, meaning not-acknowledge.
- R7: While the count is 1 and `ack_en` is 1, `ack_out` equals the policy bit (1 = acknowledge, 0 = not-acknowledge). This follows combinationally, with no clock delay.
- R8: `cfg_wr` loads the count and the policy bit only when `fifo_en` and `irq_flag` are both 1 on that edge. At any other time it changes nothing.
- R9: A pulse on `irq_wr` with `irq_wr_val` = 0 clears `irq_flag` on the next edge. A write of 1 has no effect. A set event on the same edge wins over a clear.
- R10: A pulse on `tx_done` while `tx_fifo_empty` is 1 sets both `txe_flag` and `irq_flag` on that edge. A pulse with `tx_fifo_empty` = 0 sets neither.
- R11: A clearing write to the interrupt flag also clears `txe_flag`, but only if `tx_fifo_empty` is 0 at that time. Otherwise `txe_flag` stays set.
- R12: A byte taken while the count is already 0 leaves the count at 0 and does not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable; qualifies configuration writes |
| ack_en | input | 1 | General acknowledge enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cnt | input | 4 | Count to load (0 means 16) |
| cfg_ack_last | input | 1 | Policy bit to load for the final byte |
| irq_wr | input | 1 | Interrupt flag write strobe |
| irq_wr_val | input | 1 | Value written to the interrupt flag (only 0 acts) |
| rx_valid | input | 1 | Shifter has a finished received byte |
| rx_ready | output | 1 | Block can take a byte (low while the interrupt is set) |
| ack_out | output | 1 | Acknowledge level for the byte in flight, 1 = acknowledge |
| tx_done | input | 1 | Pulse: a transmit byte including its acknowledge bit finished |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| rd_cnt | output | 4 | Low 4 bits of the remaining byte count |
| rd_ack_last | output | 1 | Stored final-byte policy bit |
| irq_flag | output | 1 | Interrupt flag |
| txe_flag | output | 1 | Transmit-empty flag |

## Verification
Registered results (`rd_cnt`, `rd_ack_last`, `irq_flag`, `txe_flag`, `rx_ready`) are due on the first rising edge after the stimulus is driven. `ack_out` follows the count, the policy bit and `ack_en` with no delay. Each driver task changes the inputs on a falling edge and waits for the next rising edge. It then pushes the predicted register state into the scoreboard 1 ns later, and the monitor compares it before the next falling edge can move any input. Checks of `ack_out` against a changed `ack_en` are pushed 1 ns after the falling edge, with no clock edge in between. Both sampling points stay clear of the active edge.

// File: rtl/i2c_rxc_pkg.sv
package i2c_rxc_pkg;

  // Acknowledge level presented to the byte shifter
  typedef enum logic {
    RSP_NACK = 1'b0,
    RSP_ACK  = 1'b1
  } ack_rsp_e;

  // Value stored when software programs a zero count: 2**cnt_w bytes
  function automatic logic [7:0] full_count(input int unsigned cnt_w);
    full_count = 8'(1 << cnt_w);
  endfunction

endpackage

// File: rtl/rxc_count_reg.sv
module rxc_count_reg #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned LOAD_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_pol,
  input  logic              byte_take,
  output logic [LOAD_W-1:0] cnt_q,
  output logic              pol_q,
  output logic              last_byte
);
  import i2c_rxc_pkg::*;

  localparam logic [LOAD_W-1:0] FULL = LOAD_W'(full_count(CNT_W));
  localparam logic [LOAD_W-1:0] ONE  = LOAD_W'(1);

  logic do_load;
  logic do_dec;

  assign do_load   = cfg_wr && wr_ok;
  assign do_dec    = byte_take && (cnt_q != '0);
  assign last_byte = byte_take && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else if (do_load) begin
      cnt_q <= (cfg_cnt == '0) ? FULL : {1'b0, cfg_cnt};
      pol_q <= cfg_pol;
    end else if (do_dec) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // R2: an accepted zero write stores the full count
  a_r2_zero_loads_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && wr_ok && (cfg_cnt == '0) |=> cnt_q == FULL);

  // R3: a taken byte lowers a non-zero count by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take && !(cfg_wr && wr_ok) && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  // R12: an empty count stays empty
  a_r12_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && wr_ok) && (cnt_q == '0) |=> cnt_q == '0);

  // R8: without write permission the stored state only counts down
  a_r8_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok && !byte_take |=> $stable(cnt_q) && $stable(pol_q));

endmodule

// File: rtl/rxc_ack_decide.sv
module rxc_ack_decide #(
  parameter int unsigned LOAD_W = 5
) (
  input  logic              ack_en,
  input  logic [LOAD_W-1:0] cnt,
  input  logic              pol,
  output logic              ack
);
  import i2c_rxc_pkg::*;

  ack_rsp_e rsp;

  always_comb begin
    if (!ack_en) begin
      rsp = RSP_NACK;
    end else if (cnt == LOAD_W'(1)) begin
      rsp = pol ? RSP_ACK : RSP_NACK;
    end else begin
      rsp = RSP_ACK;
    end
  end

  assign ack = (rsp == RSP_ACK);

endmodule

// File: rtl/rxc_flag_ctrl.sv
module rxc_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic last_byte,
  input  logic tx_done,
  input  logic tx_empty,
  input  logic irq_wr,
  input  logic irq_wr_val,
  output logic irq_q,
  output logic txe_q
);
  logic tx_evt;
  logic irq_set;
  logic irq_clr;

  assign tx_evt  = tx_done && tx_empty;
  assign irq_set = last_byte || tx_evt;
  assign irq_clr = irq_wr && !irq_wr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_set) begin
      irq_q <= 1'b1;
    end else if (irq_clr) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b0;
    end else if (tx_evt) begin
      txe_q <= 1'b1;
    end else if (irq_clr && irq_q && !tx_empty) begin
      txe_q <= 1'b0;
    end
  end

  // R5: the final byte raises the interrupt
  a_r5_last_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> irq_q);

  // R10: a transmit-empty completion raises both flags
  a_r10_txe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && tx_empty |=> irq_q && txe_q);

  // R9: a zero write with no competing event clears the interrupt
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr && !irq_wr_val && !last_byte && !(tx_done && tx_empty) |=> !irq_q);

  // R9: the interrupt never rises without an event
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !last_byte && !(tx_done && tx_empty) |=> !irq_q);

  // R11: the transmit-empty flag holds while the FIFO is still empty
  a_r11_txe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    txe_q && tx_empty |=> txe_q);

endmodule

// File: rtl/i2c_rx_count_ctrl.sv
module i2c_rx_count_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             ack_en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             cfg_ack_last,
  input  logic             irq_wr,
  input  logic             irq_wr_val,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic             ack_out,
  input  logic             tx_done,
  input  logic             tx_fifo_empty,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_ack_last,
  output logic             irq_flag,
  output logic             txe_flag
);
  localparam int unsigned LOAD_W = CNT_W + 1;

  logic [LOAD_W-1:0] cnt_q;
  logic              pol_q;
  logic              last_byte;
  logic              byte_take;
  logic              wr_ok;
  logic              irq_q;
  logic              txe_q;

  assign rx_ready  = !irq_q;
  assign byte_take = rx_valid && rx_ready;
  assign wr_ok     = fifo_en && irq_q;

  rxc_count_reg #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .cfg_wr    (cfg_wr),
    .cfg_cnt   (cfg_cnt),
    .cfg_pol   (cfg_ack_last),
    .byte_take (byte_take),
    .cnt_q     (cnt_q),
    .pol_q     (pol_q),
    .last_byte (last_byte)
  );

  rxc_ack_decide #(.LOAD_W(LOAD_W)) u_ack (
    .ack_en (ack_en),
    .cnt    (cnt_q),
    .pol    (pol_q),
    .ack    (ack_out)
  );

  rxc_flag_ctrl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_byte  (last_byte),
    .tx_done    (tx_done),
    .tx_empty   (tx_fifo_empty),
    .irq_wr     (irq_wr),
    .irq_wr_val (irq_wr_val),
    .irq_q      (irq_q),
    .txe_q      (txe_q)
  );

  assign rd_cnt      = cnt_q[CNT_W-1:0];
  assign rd_ack_last = pol_q;
  assign irq_flag    = irq_q;
  assign txe_flag    = txe_q;

  // R4: offered bytes are not counted while the interrupt is set
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !cfg_wr |=> $stable(cnt_q));

  // R6: general acknowledge off means not-acknowledge for every byte
  a_r6_no_ack_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |-> !ack_out);

  // R7: final byte with policy 0 is refused
  a_r7_last_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en && (cnt_q == LOAD_W'(1)) && !pol_q |-> !ack_out);

endmodule

// File: tb/sim_i2c_rx_count_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_rx_count_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, ack_en = 1'b0;
  logic       cfg_wr = 1'b0, cfg_ack_last = 1'b0;
  logic [3:0] cfg_cnt = '0;
  logic       irq_wr = 1'b0, irq_wr_val = 1'b0;
  logic       rx_valid = 1'b0, tx_done = 1'b0, tx_fifo_empty = 1'b0;
  logic       rx_ready, ack_out, rd_ack_last, irq_flag, txe_flag;
  logic [3:0] rd_cnt;

  always #2 clk = ~clk;

  i2c_rx_count_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ack_en(ack_en),
    .cfg_wr(cfg_wr), .cfg_cnt(cfg_cnt), .cfg_ack_last(cfg_ack_last),
    .irq_wr(irq_wr), .irq_wr_val(irq_wr_val),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .ack_out(ack_out),
    .tx_done(tx_done), .tx_fifo_empty(tx_fifo_empty),
    .rd_cnt(rd_cnt), .rd_ack_last(rd_ack_last),
    .irq_flag(irq_flag), .txe_flag(txe_flag)
  );

  typedef struct {
    string      req;
    logic [3:0] cnt;
    logic       pol, irq, txe, ack, rdy;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  // Requirement-level model
  int m_cnt = 0;
  bit m_pol = 0, m_irq = 0, m_txe = 0;

  task automatic push(input string req);
    exp_t e;
    e.req = req;
    e.cnt = 4'(m_cnt);
    e.pol = m_pol;
    e.irq = m_irq;
    e.txe = m_txe;
    e.ack = ack_en ? ((m_cnt == 1) ? m_pol : 1'b1) : 1'b0;
    e.rdy = !m_irq;
    sb.push_back(e);
  endtask

  // Monitor: pops predictions and compares them with the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() != 0);
      e = sb.pop_front();
      n_chk++;
      if ({rd_cnt, rd_ack_last, irq_flag, txe_flag, ack_out, rx_ready} !==
          {e.cnt, e.pol, e.irq, e.txe, e.ack, e.rdy}) begin
        n_err++;
        $display("FAIL %s: actual cnt=%0d pol=%b irq=%b txe=%b ack=%b rdy=%b expected cnt=%0d pol=%b irq=%b txe=%b ack=%b rdy=%b",
                 e.req, rd_cnt, rd_ack_last, irq_flag, txe_flag, ack_out, rx_ready,
                 e.cnt, e.pol, e.irq, e.txe, e.ack, e.rdy);
      end
    end
  end

  task automatic begin_op();
    @(negedge clk);
    cfg_wr = 0; irq_wr = 0; rx_valid = 0; tx_done = 0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic do_rx(input string req);
    begin_op();
    rx_valid = 1;
    if (!m_irq) begin
      if (m_cnt == 1) begin m_cnt = 0; m_irq = 1; end
      else if (m_cnt != 0) m_cnt--;
    end
    settle();
    push(req);
  endtask

  task automatic do_cfg(input int v, input bit p, input string req);
    begin_op();
    cfg_wr = 1; cfg_cnt = 4'(v); cfg_ack_last = p;
    if (fifo_en && m_irq) begin
      m_cnt = (v == 0) ? 16 : v;
      m_pol = p;
    end
    settle();
    push(req);
  endtask

  task automatic do_irq_wr(input bit v, input string req);
    begin_op();
    irq_wr = 1; irq_wr_val = v;
    if (!v && m_irq) begin
      m_irq = 0;
      if (!tx_fifo_empty) m_txe = 0;
    end
    settle();
    push(req);
  endtask

  task automatic do_tx(input bit empty, input string req);
    begin_op();
    tx_done = 1; tx_fifo_empty = empty;
    if (empty) begin m_irq = 1; m_txe = 1; end
    settle();
    push(req);
  endtask

  task automatic set_ack_en(input bit v, input string req);
    begin_op();
    ack_en = v;
    #1;
    push(req);
  endtask

  initial begin
    #(4 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push("R1 reset state");
    @(negedge clk);
    rst_n = 1;
    settle();
    push("R1 after release");

    fifo_en = 1;
    do_cfg(5, 1, "R8 write ignored while irq clear");
    do_rx("R12 byte at count 0");
    do_tx(0, "R10 tx done with data left");
    do_tx(1, "R10 tx done with fifo empty");
    do_rx("R4 byte refused while irq set");
    do_irq_wr(1, "R9 write of one has no effect");
    fifo_en = 0;
    do_cfg(3, 0, "R8 write ignored while fifo disabled");
    fifo_en = 1;
    do_cfg(3, 0, "R8 write accepted");
    do_irq_wr(0, "R11 clear with tx fifo still empty keeps txe");

    set_ack_en(1, "R6 ack at count 3");
    do_rx("R3 count 3 to 2");
    do_rx("R7 count 2 to 1 policy nack");
    set_ack_en(0, "R6 ack disabled at count 1");
    set_ack_en(1, "R7 nack on final byte");
    do_rx("R5 final byte raises irq");
    do_rx("R4 no count while irq set");

    do_tx(0, "R10 tx fifo refilled, no set");
    do_cfg(0, 1, "R2 zero write loads sixteen");
    do_irq_wr(0, "R11 clear with data clears txe");
    for (int i = 0; i < 15; i++) begin
      do_rx((m_cnt == 2) ? "R7 count reaches 1, policy ack" : "R3 count down");
    end
    if (rd_cnt !== 4'd1 || ack_out !== 1'b1 || irq_flag !== 1'b0) begin
      n_err++;
      $display("FAIL R2: actual cnt=%0d ack=%b irq=%b expected cnt=1 ack=1 irq=0",
               rd_cnt, ack_out, irq_flag);
    end
    n_chk++;
    do_rx("R2 sixteenth byte raises irq");

    begin_op();
    irq_wr = 1; irq_wr_val = 0; tx_done = 1; tx_fifo_empty = 1;
    m_irq = 1; m_txe = 1;
    settle();
    push("R9 set wins over clear");
    begin_op();

    wait (sb.size() == 0);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule